// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the raster timing for a parallel RGB TFT panel. It runs on the pixel clock. It outputs horizontal sync, vertical sync and data-enable strobes, the current pixel and line position, a one-cycle frame-start pulse and a tearing-effect flag. All geometry comes from static configuration inputs:

- active width, set in groups of eight pixels, and the horizontal blanking length;
- active height and the vertical blanking length;
- sync pulse widths, start offsets and polarities;
- the data-enable mode and the tearing-effect mode.

Each line and each frame has its active part first. Blanking starts on the pixel or line right after the last active one, and each sync start offset is counted from the start of that blanking. A master enable parks the outputs at idle levels and clears the counters. The configuration inputs are captured into a shadow copy while the block is disabled and again at every frame wrap, so a change made mid-frame first takes effect at pixel 0 of line 0.

Top module: `raster_timer`

## Requirements
- R1: While `rstN` is low, all outputs are 0.
- R2: One clock after `dispEnable` is sampled low, the outputs are idle. `hsOut` sits at the inverse of its polarity bit and `vsOut` at the inverse of its polarity bit. `deOut`, `teOut` and `frameStart` are 0, and `pixelX` and `lineY` are 0.
- R3: One clock after `dispEnable` is first sampled high, the outputs show pixel 0 of line 0. After that, `pixelX` counts up to `hActUnits*8 + hBlank - 1` and wraps to 0. `lineY` advances on each wrap and returns to 0 after line `vActLines + vBlank - 1`.
- R4: `frameStart` is 1 exactly in the cycle that reports pixel 0 of line 0 while enabled.
- R5: `hsOut` is at its active level (high when `hsActiveHigh` is 1, low when it is 0) for pixels in [A, A + `hsWidth`), where A = `hActUnits*8 + hsStart`. Outside that range it is at the opposite level. A pulse that runs past the end of the line is cut off.
- R6: `vsOut` behaves the same way on lines, with B = `vActLines + vsStart`, width `vsWidth` and polarity `vsActiveHigh`.
- R7: Let the active area be pixel < `hActUnits*8` and line < `vActLines`. With `deMode` 0, `deOut` is low in the active area and high elsewhere. With `deMode` 1 it is high in the active area. With `deMode` 2 it is always low, and with `deMode` 3 it is always high while enabled.
- R8: With `teMode` 0, `teOut` is 0. With `teMode` 1, it is 1 on blanking lines (line >= `vActLines`) and 0 on active lines. With `teMode` 2, it is 1 on the line equal to `teLine`. With `teMode` 3 (reserved), it is 0.
- R9: When `teOff` is 1, `teOut` is 0 whatever the `teMode` setting.
- R10: A configuration change made while enabled leaves the current frame unchanged. It first applies at the next pixel 0 of line 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Asynchronous reset, active low |
| dispEnable | input | 1 | Master enable; low parks outputs and clears counters |
| hActUnits | input | 7 | Active width in groups of 8 pixels |
| hBlank | input | 7 | Horizontal blanking length in pixels |
| vActLines | input | 10 | Active height in lines |
| vBlank | input | 8 | Vertical blanking length in lines |
| hsWidth | input | 7 | HS pulse width in pixels |
| hsStart | input | 7 | HS start offset from start of horizontal blanking |
| hsActiveHigh | input | 1 | 1: HS active high, 0: active low |
| vsWidth | input | 6 | VS pulse width in lines |
| vsStart | input | 8 | VS start offset from start of vertical blanking |
| vsActiveHigh | input | 1 | 1: VS active high, 0: active low |
| deMode | input | 2 | Data-enable mode (see R7) |
| teMode | input | 2 | Tearing-effect mode (see R8) |
| teLine | input | 10 | Line number matched in tearing-effect mode 2 |
| teOff | input | 1 | Forces the tearing-effect output low |
| hsOut | output | 1 | Horizontal sync |
| vsOut | output | 1 | Vertical sync |
| deOut | output | 1 | Data enable |
| teOut | output | 1 | Tearing-effect flag |
| frameStart | output | 1 | One-cycle pulse at pixel 0 of line 0 |
| pixelX | output | 11 | Current pixel position in the line |
| lineY | output | 11 | Current line position in the frame |

## Verification
Every output is registered once after the counters. Each strobe therefore describes the position held by the counters before the same clock edge. The first position after enable, pixel 0 of line 0, appears one clock after `dispEnable` is sampled high, and the idle levels appear one clock after it is sampled low. The bench holds its own counters and shadow configuration. Before each rising edge it computes the outputs due after that edge from the inputs it is driving, then compares them at the following falling edge. Configuration changes made in the middle of a frame are therefore expected only from the cycle that reports the next frame start.

// File: rtl/raster_pkg.sv
package raster_pkg;

  localparam int HUNIT_W     = 7;
  localparam int HUNIT_SHIFT = 3;
  localparam int HBLANK_W    = 7;
  localparam int VACT_W      = 10;
  localparam int VBLANK_W    = 8;
  localparam int HSW_W       = 7;
  localparam int HSS_W       = 7;
  localparam int VSW_W       = 6;
  localparam int VSS_W       = 8;
  localparam int TELINE_W    = 10;

  localparam int HACT_W = HUNIT_W + HUNIT_SHIFT;
  localparam int HCNT_W = ((HACT_W > HBLANK_W) ? HACT_W : HBLANK_W) + 1;
  localparam int VCNT_W = ((VACT_W > VBLANK_W) ? VACT_W : VBLANK_W) + 1;

  typedef enum logic [1:0] {
    DE_LOW_ACTIVE  = 2'd0,
    DE_HIGH_ACTIVE = 2'd1,
    DE_FORCE_LOW   = 2'd2,
    DE_FORCE_HIGH  = 2'd3
  } deMode_e;

  typedef enum logic [1:0] {
    TE_NONE   = 2'd0,
    TE_VBLANK = 2'd1,
    TE_LINE   = 2'd2,
    TE_RSVD   = 2'd3
  } teMode_e;

  typedef struct packed {
    logic [HUNIT_W-1:0]  hActUnits;
    logic [HBLANK_W-1:0] hBlank;
    logic [VACT_W-1:0]   vActLines;
    logic [VBLANK_W-1:0] vBlank;
    logic [HSW_W-1:0]    hsWidth;
    logic [HSS_W-1:0]    hsStart;
    logic                hsActiveHigh;
    logic [VSW_W-1:0]    vsWidth;
    logic [VSS_W-1:0]    vsStart;
    logic                vsActiveHigh;
    deMode_e             deMode;
    teMode_e             teMode;
    logic [TELINE_W-1:0] teLine;
    logic                teOff;
  } timingCfg_t;

  // Output-shaping settings handed from control to datapath
  typedef struct packed {
    logic    hsPol;
    logic    vsPol;
    deMode_e deMode;
    teMode_e teMode;
    logic    teOff;
  } outMode_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic              run;
    logic              hActive;
    logic              vActive;
    logic              hsHit;
    logic              vsHit;
    logic              teLineHit;
    logic              frameStart;
    logic [HCNT_W-1:0] px;
    logic [VCNT_W-1:0] ln;
  } strobe_t;

endpackage

// File: rtl/raster_window.sv
// Half-open window test: base+offset <= pos < base+offset+length
module raster_window #(
  parameter int POS_W = 11,
  parameter int OFF_W = 7,
  parameter int LEN_W = 7
) (
  input  logic [POS_W-1:0] pos,
  input  logic [POS_W-1:0] base,
  input  logic [OFF_W-1:0] offset,
  input  logic [LEN_W-1:0] length,
  output logic             hit
);
  localparam int SUM_W = POS_W + 2;

  logic [SUM_W-1:0] startPos;
  logic [SUM_W-1:0] endPos;
  logic [SUM_W-1:0] posExt;

  always_comb begin
    startPos = SUM_W'(base) + SUM_W'(offset);
    endPos   = startPos + SUM_W'(length);
    posExt   = SUM_W'(pos);
    hit      = (posExt >= startPos) && (posExt < endPos);
  end
endmodule

// File: rtl/raster_ctrl.sv
// Counters, configuration shadow and window strobes
module raster_ctrl
  import raster_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  timingCfg_t cfgIn,
  output outMode_t   modeOut,
  output strobe_t    stb
);
  timingCfg_t        shadowQ;
  logic [HCNT_W-1:0] hCnt;
  logic [VCNT_W-1:0] vCnt;
  logic [HCNT_W-1:0] hActPix;
  logic [HCNT_W-1:0] hTotal;
  logic [HCNT_W-1:0] hLast;
  logic [VCNT_W-1:0] vAct;
  logic [VCNT_W-1:0] vTotal;
  logic [VCNT_W-1:0] vLast;
  logic              lineEnd;
  logic              frameEnd;
  logic              hsHit;
  logic              vsHit;

  always_comb begin
    hActPix  = HCNT_W'({shadowQ.hActUnits, {HUNIT_SHIFT{1'b0}}});
    hTotal   = hActPix + HCNT_W'(shadowQ.hBlank);
    hLast    = (hTotal == '0) ? '0 : hTotal - 1'b1;
    vAct     = VCNT_W'(shadowQ.vActLines);
    vTotal   = vAct + VCNT_W'(shadowQ.vBlank);
    vLast    = (vTotal == '0) ? '0 : vTotal - 1'b1;
    lineEnd  = (hCnt >= hLast);
    frameEnd = lineEnd && (vCnt >= vLast);
  end

  raster_window #(.POS_W(HCNT_W), .OFF_W(HSS_W), .LEN_W(HSW_W)) hsWin (
    .pos(hCnt), .base(hActPix), .offset(shadowQ.hsStart),
    .length(shadowQ.hsWidth), .hit(hsHit)
  );

  raster_window #(.POS_W(VCNT_W), .OFF_W(VSS_W), .LEN_W(VSW_W)) vsWin (
    .pos(vCnt), .base(vAct), .offset(shadowQ.vsStart),
    .length(shadowQ.vsWidth), .hit(vsHit)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hCnt    <= '0;
      vCnt    <= '0;
      shadowQ <= '0;
    end else if (!enable) begin
      hCnt    <= '0;
      vCnt    <= '0;
      shadowQ <= cfgIn;
    end else if (lineEnd) begin
      hCnt <= '0;
      if (frameEnd) begin
        vCnt    <= '0;
        shadowQ <= cfgIn;
      end else begin
        vCnt <= vCnt + 1'b1;
      end
    end else begin
      hCnt <= hCnt + 1'b1;
    end
  end

  always_comb begin
    stb.run        = enable;
    stb.hActive    = (hCnt < hActPix);
    stb.vActive    = (vCnt < vAct);
    stb.hsHit      = hsHit;
    stb.vsHit      = vsHit;
    stb.teLineHit  = (vCnt == VCNT_W'(shadowQ.teLine));
    stb.frameStart = (hCnt == '0) && (vCnt == '0);
    stb.px         = hCnt;
    stb.ln         = vCnt;

    modeOut.hsPol  = shadowQ.hsActiveHigh;
    modeOut.vsPol  = shadowQ.vsActiveHigh;
    modeOut.deMode = shadowQ.deMode;
    modeOut.teMode = shadowQ.teMode;
    modeOut.teOff  = shadowQ.teOff;
  end
endmodule

// File: rtl/raster_out.sv
// Output shaping and registering
module raster_out
  import raster_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  outMode_t          mode,
  output logic              hsOut,
  output logic              vsOut,
  output logic              deOut,
  output logic              teOut,
  output logic              frameStart,
  output logic [HCNT_W-1:0] pixelX,
  output logic [VCNT_W-1:0] lineY
);
  logic activeArea;
  logic deNext;
  logic teSel;
  logic hsNext;
  logic vsNext;

  always_comb begin
    activeArea = stb.hActive && stb.vActive;
    unique case (mode.deMode)
      DE_LOW_ACTIVE:  deNext = !activeArea;
      DE_HIGH_ACTIVE: deNext = activeArea;
      DE_FORCE_LOW:   deNext = 1'b0;
      default:        deNext = 1'b1;
    endcase
    unique case (mode.teMode)
      TE_VBLANK: teSel = !stb.vActive;
      TE_LINE:   teSel = stb.teLineHit;
      default:   teSel = 1'b0;
    endcase
    hsNext = (stb.run && stb.hsHit) ? mode.hsPol : !mode.hsPol;
    vsNext = (stb.run && stb.vsHit) ? mode.vsPol : !mode.vsPol;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hsOut      <= 1'b0;
      vsOut      <= 1'b0;
      deOut      <= 1'b0;
      teOut      <= 1'b0;
      frameStart <= 1'b0;
      pixelX     <= '0;
      lineY      <= '0;
    end else begin
      hsOut      <= hsNext;
      vsOut      <= vsNext;
      deOut      <= stb.run && deNext;
      teOut      <= stb.run && teSel && !mode.teOff;
      frameStart <= stb.run && stb.frameStart;
      pixelX     <= stb.run ? stb.px : '0;
      lineY      <= stb.run ? stb.ln : '0;
    end
  end
endmodule

// File: rtl/raster_timer.sv
module raster_timer
  import raster_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                dispEnable,
  input  logic [HUNIT_W-1:0]  hActUnits,
  input  logic [HBLANK_W-1:0] hBlank,
  input  logic [VACT_W-1:0]   vActLines,
  input  logic [VBLANK_W-1:0] vBlank,
  input  logic [HSW_W-1:0]    hsWidth,
  input  logic [HSS_W-1:0]    hsStart,
  input  logic                hsActiveHigh,
  input  logic [VSW_W-1:0]    vsWidth,
  input  logic [VSS_W-1:0]    vsStart,
  input  logic                vsActiveHigh,
  input  logic [1:0]          deMode,
  input  logic [1:0]          teMode,
  input  logic [TELINE_W-1:0] teLine,
  input  logic                teOff,
  output logic                hsOut,
  output logic                vsOut,
  output logic                deOut,
  output logic                teOut,
  output logic                frameStart,
  output logic [HCNT_W-1:0]   pixelX,
  output logic [VCNT_W-1:0]   lineY
);
  timingCfg_t cfg;
  outMode_t   mode;
  strobe_t    stb;

  always_comb begin
    cfg.hActUnits    = hActUnits;
    cfg.hBlank       = hBlank;
    cfg.vActLines    = vActLines;
    cfg.vBlank       = vBlank;
    cfg.hsWidth      = hsWidth;
    cfg.hsStart      = hsStart;
    cfg.hsActiveHigh = hsActiveHigh;
    cfg.vsWidth      = vsWidth;
    cfg.vsStart      = vsStart;
    cfg.vsActiveHigh = vsActiveHigh;
    cfg.deMode       = deMode_e'(deMode);
    cfg.teMode       = teMode_e'(teMode);
    cfg.teLine       = teLine;
    cfg.teOff        = teOff;
  end

  raster_ctrl ctrl (
    .clk(clk), .rstN(rstN), .enable(dispEnable),
    .cfgIn(cfg), .modeOut(mode), .stb(stb)
  );

  raster_out dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .mode(mode),
    .hsOut(hsOut), .vsOut(vsOut), .deOut(deOut), .teOut(teOut),
    .frameStart(frameStart), .pixelX(pixelX), .lineY(lineY)
  );
endmodule

// File: rtl/raster_checker.sv
module raster_checker
  import raster_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              dispEnable,
  input logic              deOut,
  input logic              teOut,
  input logic              frameStart,
  input logic [HCNT_W-1:0] pixelX,
  input logic [VCNT_W-1:0] lineY
);
  assert_frame_origin_R4: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |-> (pixelX == '0 && lineY == '0));

  assert_first_frame_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dispEnable) |=> frameStart);

  assert_pixel_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    (pixelX != '0) |-> (pixelX == $past(pixelX) + 1'b1));

  assert_line_on_wrap_R3: assert property (@(posedge clk) disable iff (!rstN)
    (lineY != $past(lineY)) |-> (pixelX == '0));

  assert_idle_levels_R2: assert property (@(posedge clk) disable iff (!rstN)
    !dispEnable |=> (!deOut && !teOut && !frameStart && pixelX == '0 && lineY == '0));
endmodule

bind raster_timer raster_checker chk (
  .clk(clk), .rstN(rstN), .dispEnable(dispEnable), .deOut(deOut),
  .teOut(teOut), .frameStart(frameStart), .pixelX(pixelX), .lineY(lineY)
);

// File: tb/raster_timer_test.sv
module raster_timer_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic dispEnable = 1'b0;
  logic [6:0] hActUnits = '0;
  logic [6:0] hBlank = '0;
  logic [9:0] vActLines = '0;
  logic [7:0] vBlank = '0;
  logic [6:0] hsWidth = '0;
  logic [6:0] hsStart = '0;
  logic hsActiveHigh = 1'b0;
  logic [5:0] vsWidth = '0;
  logic [7:0] vsStart = '0;
  logic vsActiveHigh = 1'b0;
  logic [1:0] deMode = '0;
  logic [1:0] teMode = '0;
  logic [9:0] teLine = '0;
  logic teOff = 1'b0;
  logic hsOut, vsOut, deOut, teOut, frameStart;
  logic [10:0] pixelX, lineY;

  raster_timer uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 0;
  bit tagR10 = 0;

  // bench model state
  int mx = 0, my = 0;
  int sHActU = 0, sHBlank = 0, sVAct = 0, sVBlank = 0, sHsW = 0, sHsS = 0;
  int sHsPol = 0, sVsW = 0, sVsS = 0, sVsPol = 0, sDe = 0, sTe = 0, sTeLine = 0, sTeOff = 0;
  int eHs, eVs, eDe, eTe, eFs, eX, eY;
  bit eRun;
  bit eTeOffUsed;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic latchCfg();
    sHActU = hActUnits; sHBlank = hBlank; sVAct = vActLines; sVBlank = vBlank;
    sHsW = hsWidth; sHsS = hsStart; sHsPol = hsActiveHigh;
    sVsW = vsWidth; sVsS = vsStart; sVsPol = vsActiveHigh;
    sDe = deMode; sTe = teMode; sTeLine = teLine; sTeOff = teOff;
  endtask

  task automatic predict();
    int hAct, hTot, vTot, hLast, vLast, act, te;
    hAct = sHActU * 8;
    hTot = hAct + sHBlank;
    vTot = sVAct + sVBlank;
    hLast = (hTot == 0) ? 0 : hTot - 1;
    vLast = (vTot == 0) ? 0 : vTot - 1;
    eRun = dispEnable;
    eTeOffUsed = (sTeOff != 0);
    if (!dispEnable) begin
      eHs = !sHsPol; eVs = !sVsPol; eDe = 0; eTe = 0; eFs = 0; eX = 0; eY = 0;
      mx = 0; my = 0;
      latchCfg();
    end else begin
      eX = mx; eY = my;
      eFs = (mx == 0 && my == 0);
      eHs = (mx >= hAct + sHsS && mx < hAct + sHsS + sHsW) ? sHsPol : !sHsPol;
      eVs = (my >= sVAct + sVsS && my < sVAct + sVsS + sVsW) ? sVsPol : !sVsPol;
      act = (mx < hAct && my < sVAct);
      case (sDe)
        0: eDe = !act;
        1: eDe = act;
        2: eDe = 0;
        default: eDe = 1;
      endcase
      case (sTe)
        1: te = (my >= sVAct);
        2: te = (my == sTeLine);
        default: te = 0;
      endcase
      eTe = sTeOff ? 0 : te;
      if (mx >= hLast) begin
        mx = 0;
        if (my >= vLast) begin
          my = 0;
          latchCfg();
        end else my++;
      end else mx++;
    end
  endtask

  task automatic compareAll();
    string tp, tf, th, tv, td, tt;
    if (!eRun) begin
      tp = "R2"; tf = "R2"; th = "R2"; tv = "R2"; td = "R2"; tt = "R2";
    end else begin
      tp = "R3"; tf = "R4"; th = tagR10 ? "R10" : "R5"; tv = "R6"; td = "R7";
      tt = eTeOffUsed ? "R9" : "R8";
    end
    check(int'(pixelX) == eX, tp, "pixelX", pixelX, eX);
    check(int'(lineY) == eY, tp, "lineY", lineY, eY);
    check(int'(frameStart) == eFs, tf, "frameStart", frameStart, eFs);
    check(int'(hsOut) == eHs, th, "hsOut", hsOut, eHs);
    check(int'(vsOut) == eVs, tv, "vsOut", vsOut, eVs);
    check(int'(deOut) == eDe, td, "deOut", deOut, eDe);
    check(int'(teOut) == eTe, tt, "teOut", teOut, eTe);
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      predict();
      @(posedge clk);
      @(negedge clk);
      compareAll();
    end
  endtask

  task automatic setGeom(input int ha, input int hb, input int va, input int vb,
                         input int hw, input int hs, input int vw, input int vs);
    hActUnits = 7'(ha); hBlank = 7'(hb); vActLines = 10'(va); vBlank = 8'(vb);
    hsWidth = 7'(hw); hsStart = 7'(hs); vsWidth = 6'(vw); vsStart = 8'(vs);
  endtask

  int frameLen;

  initial begin
    // R1: reset state
    repeat (2) @(negedge clk);
    check(hsOut == 0 && vsOut == 0 && deOut == 0 && teOut == 0 && frameStart == 0,
          "R1", "reset strobes", {hsOut, vsOut, deOut, teOut, frameStart}, 0);
    check(pixelX == 0 && lineY == 0, "R1", "reset counters", pixelX + lineY, 0);
    rstN = 1'b1;
    mx = 0; my = 0;

    setGeom(2, 6, 4, 3, 3, 1, 1, 1);
    teLine = 10'd2;
    frameLen = (2 * 8 + 6) * (4 + 3);

    // R2: idle levels under each polarity pair
    for (int p = 0; p < 4; p++) begin
      hsActiveHigh = p[0]; vsActiveHigh = p[1];
      tick(3);
    end

    // R3..R8: sweep every DE mode against every TE mode
    for (int d = 0; d < 4; d++) begin
      for (int t = 0; t < 4; t++) begin
        deMode = 2'(d); teMode = 2'(t);
        hsActiveHigh = d[0]; vsActiveHigh = t[0];
        teOff = 1'b0;
        dispEnable = 1'b0;
        tick(2);
        dispEnable = 1'b1;
        tick(frameLen + 8);
      end
    end

    // R9: TE disable overrides both active TE modes
    for (int t = 1; t < 3; t++) begin
      teMode = 2'(t); teOff = 1'b1;
      dispEnable = 1'b0;
      tick(2);
      dispEnable = 1'b1;
      tick(frameLen + 4);
    end
    teOff = 1'b0;

    // R3, R5, R6: geometry corners (zero active, minimal, sync past end, zero VS width)
    for (int g = 0; g < 4; g++) begin
      case (g)
        0: setGeom(0, 5, 0, 2, 2, 1, 1, 0);
        1: setGeom(1, 1, 1, 1, 1, 0, 1, 0);
        2: setGeom(3, 10, 6, 2, 5, 8, 0, 1);
        default: setGeom(1, 4, 3, 5, 9, 2, 7, 3);
      endcase
      deMode = 2'(g); teMode = 2'((g + 1) % 3); teLine = 10'(g + 1);
      dispEnable = 1'b0;
      tick(2);
      dispEnable = 1'b1;
      tick(2 * ((hActUnits * 8 + hBlank) * (vActLines + vBlank)) + 3);
    end

    // R10: change sync and DE settings in the middle of a frame
    setGeom(2, 6, 4, 3, 3, 1, 1, 1);
    deMode = 2'd1; teMode = 2'd1; hsActiveHigh = 1'b1;
    dispEnable = 1'b0;
    tick(2);
    dispEnable = 1'b1;
    tick(frameLen / 2);
    tagR10 = 1'b1;
    hsStart = 7'd3; hsWidth = 7'd2; hsActiveHigh = 1'b0; deMode = 2'd0;
    tick(frameLen * 2);
    tagR10 = 1'b0;

    // R2, R3: drop enable mid-frame, then restart
    tick(37);
    dispEnable = 1'b0;
    tick(3);
    dispEnable = 1'b1;
    tick(frameLen + 2);

    finished = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end
endmodule